// File: doc/BRIEF.md
# Scan-Chain Self-Test Sequencer with Phase-Shifted Pattern Source

This block runs logic self-test on a design built from several parallel full-scan chains of equal length. A 32-bit shift-register pattern source feeds every chain through an XOR phase-shift network. This keeps neighbouring chains from receiving delayed copies of one bit stream. The block then alternates chain-length shift passes with single functional capture cycles. A multiple-input signature register, one bit per chain, compacts what the chains shift out.

Loading and unloading overlap. The shift pass that loads pattern k+1 is the same pass that unloads the response to pattern k. The very first pass only loads, and a final pass after the last capture only unloads. Software or a test controller programs a pattern count and pulses start. It then waits for done and reads the signature, which stays frozen until the next start. The block does not compare the signature against a golden value.

Top module: `scan_bist_seq`

## Requirements
- R1: While reset is asserted and after it is released, done, scan_en, capture_en and every scan_in bit are 0, and signature equals the MISR seed, which is all ones.
- R2: A start pulse sampled while the block is idle or done reloads the pattern source with the seed 32'h1D872B41 and the signature with all ones, and latches pattern_count. A start sampled during a run has no effect on its timing or its signature, and a repeated run gives the same signature.
- R3: The pattern source q[31:0] advances once per load-shift cycle as q <= {q[30:0], q[31]^q[21]^q[1]^q[0]}, and holds in every other cycle. During load shifting, chain i receives scan_in[i] = q[i mod 32] ^ q[(3i+5) mod 32] ^ q[(7i+11) mod 32].
- R4: Each pattern is loaded by exactly CHAIN_LEN cycles with scan_en high. These are followed by exactly one cycle with scan_en low and capture_en high, so a run of P patterns raises capture_en in exactly P cycles.
- R5: The signature does not change during the first load pass of a run. In every later load pass it accumulates the chain outputs, so unloading the previous response happens in the same cycles as loading the next pattern.
- R6: In each accumulating cycle the signature s updates as s <= {s[N-2:0], s[N-1]} ^ (s[N-1] ? (1 << 3) : 0) ^ scan_out.
- R7: After the last capture, a final pass of CHAIN_LEN cycles with scan_en high accumulates the chain outputs while scan_in is held at 0. Afterwards every chain holds all zeros.
- R8: With P > 0, done rises after P*(CHAIN_LEN+1)+CHAIN_LEN+1 clock edges, counting the edge that samples start. With P = 0, done rises at the edge that samples start and the signature equals the seed. While done is high, scan_en and capture_en are low.
- R9: While done is high and start is low, done stays high and the signature does not change.
- R10: scan_en and capture_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle or done |
| pattern_count | input | CNT_W | Number of patterns to apply, latched at start |
| scan_en | output | 1 | Shift enable to all chains |
| capture_en | output | 1 | Functional capture clock enable to all chains |
| scan_in | output | NUM_CHAINS | Serial input bit for each chain |
| scan_out | input | NUM_CHAINS | Serial output bit from each chain |
| done | output | 1 | Run finished; signature valid |
| signature | output | NUM_CHAINS | Compacted response |

## Verification
Two functions fall in the same cycles in this block: loading the next pattern from the phase-shifted source, and compacting the previous response into the signature. Runs of one, two and three patterns are applied to chain and logic models inside the bench. The response of each capture depends nonlinearly on the loaded contents, so a slip in the load stream or in the unload window changes the signature. The result is judged against a signature the bench computes in software from the register equations. The run length, the capture count, the zero contents of the chains after the final pass and the first phase-shifted input word are also checked.

// File: rtl/scan_bist_pkg.sv
package scan_bist_pkg;

  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h1D87_2B41;
  localparam int MISR_TAP = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_FINAL   = 3'd3,
    ST_DONE    = 3'd4
  } bist_state_e;

  // One step of the pattern source: taps 32, 22, 2, 1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] q);
    return {q[LFSR_W-2:0], q[31] ^ q[21] ^ q[1] ^ q[0]};
  endfunction

  // Three tap positions that drive chain idx through the phase shifter
  function automatic int ps_tap_a(input int idx);
    return idx % LFSR_W;
  endfunction
  function automatic int ps_tap_b(input int idx);
    return (3 * idx + 5) % LFSR_W;
  endfunction
  function automatic int ps_tap_c(input int idx);
    return (7 * idx + 11) % LFSR_W;
  endfunction

endpackage

// File: rtl/scan_bist_lfsr.sv
module scan_bist_lfsr #(
  parameter int NUM_CHAINS = 25
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 seed_load,
  input  logic                                 advance,
  output logic [scan_bist_pkg::LFSR_W-1:0]     state_q,
  output logic [NUM_CHAINS-1:0]                ps_out
);
  import scan_bist_pkg::*;

  logic [LFSR_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= LFSR_SEED;
    end else if (seed_load) begin
      q <= LFSR_SEED;
    end else if (advance) begin
      q <= lfsr_step(q);
    end
  end

  assign state_q = q;

  for (genvar gi = 0; gi < NUM_CHAINS; gi++) begin : g_phase
    localparam int TA = ps_tap_a(gi);
    localparam int TB = ps_tap_b(gi);
    localparam int TC = ps_tap_c(gi);
    assign ps_out[gi] = q[TA] ^ q[TB] ^ q[TC];
  end

endmodule

// File: rtl/scan_bist_misr.sv
module scan_bist_misr #(
  parameter int NUM_CHAINS = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seed_load,
  input  logic                  accumulate,
  input  logic [NUM_CHAINS-1:0] data_in,
  output logic [NUM_CHAINS-1:0] sig_q
);
  import scan_bist_pkg::*;

  localparam logic [NUM_CHAINS-1:0] MISR_SEED = '1;

  logic [NUM_CHAINS-1:0] sig;
  logic [NUM_CHAINS-1:0] sig_nxt;

  for (genvar gk = 0; gk < NUM_CHAINS; gk++) begin : g_cell
    if (gk == 0) begin : g_head
      assign sig_nxt[gk] = sig[NUM_CHAINS-1] ^ data_in[gk];
    end else if (gk == MISR_TAP) begin : g_tap
      assign sig_nxt[gk] = sig[gk-1] ^ sig[NUM_CHAINS-1] ^ data_in[gk];
    end else begin : g_plain
      assign sig_nxt[gk] = sig[gk-1] ^ data_in[gk];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= MISR_SEED;
    end else if (seed_load) begin
      sig <= MISR_SEED;
    end else if (accumulate) begin
      sig <= sig_nxt;
    end
  end

  assign sig_q = sig;

endmodule

// File: rtl/scan_bist_ctrl.sv
module scan_bist_ctrl #(
  parameter int CHAIN_LEN = 200,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pattern_count,
  output logic             scan_en,
  output logic             capture_en,
  output logic             done,
  output logic             seed_load,
  output logic             load_phase,
  output logic             final_phase,
  output logic             first_load,
  output logic             misr_acc
);
  import scan_bist_pkg::*;

  localparam int SC_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(CHAIN_LEN - 1);

  bist_state_e      state;
  logic [SC_W-1:0]  shift_cnt;
  logic [CNT_W-1:0] pat_cnt;
  logic [CNT_W-1:0] pat_target;
  logic             first_q;
  logic             accept;
  logic             shift_last;
  logic             last_pattern;

  assign accept       = start && (state == ST_IDLE || state == ST_DONE);
  assign shift_last   = (shift_cnt == SC_LAST);
  assign last_pattern = ((pat_cnt + CNT_W'(1)) == pat_target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shift_cnt  <= '0;
      pat_cnt    <= '0;
      pat_target <= '0;
      first_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            pat_target <= pattern_count;
            pat_cnt    <= '0;
            shift_cnt  <= '0;
            first_q    <= 1'b1;
            state      <= (pattern_count == '0) ? ST_DONE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_last) begin
            shift_cnt <= '0;
            state     <= ST_CAPTURE;
          end else begin
            shift_cnt <= shift_cnt + SC_W'(1);
          end
        end
        ST_CAPTURE: begin
          first_q <= 1'b0;
          pat_cnt <= pat_cnt + CNT_W'(1);
          state   <= last_pattern ? ST_FINAL : ST_SHIFT;
        end
        ST_FINAL: begin
          if (shift_last) begin
            shift_cnt <= '0;
            state     <= ST_DONE;
          end else begin
            shift_cnt <= shift_cnt + SC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_phase  = (state == ST_SHIFT);
  assign final_phase = (state == ST_FINAL);
  assign scan_en     = load_phase || final_phase;
  assign capture_en  = (state == ST_CAPTURE);
  assign done        = (state == ST_DONE);
  assign seed_load   = accept;
  assign first_load  = first_q;
  assign misr_acc    = (load_phase && !first_q) || final_phase;

endmodule

// File: rtl/scan_bist_seq.sv
module scan_bist_seq #(
  parameter int NUM_CHAINS = 25,
  parameter int CHAIN_LEN  = 200,
  parameter int CNT_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      pattern_count,
  output logic                  scan_en,
  output logic                  capture_en,
  output logic [NUM_CHAINS-1:0] scan_in,
  input  logic [NUM_CHAINS-1:0] scan_out,
  output logic                  done,
  output logic [NUM_CHAINS-1:0] signature
);
  import scan_bist_pkg::*;

  logic                  seed_load;
  logic                  load_phase;
  logic                  final_phase;
  logic                  first_load;
  logic                  misr_acc;
  logic [LFSR_W-1:0]     lfsr_state;
  logic [NUM_CHAINS-1:0] ps_bits;

  scan_bist_ctrl #(
    .CHAIN_LEN(CHAIN_LEN),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .pattern_count(pattern_count),
    .scan_en      (scan_en),
    .capture_en   (capture_en),
    .done         (done),
    .seed_load    (seed_load),
    .load_phase   (load_phase),
    .final_phase  (final_phase),
    .first_load   (first_load),
    .misr_acc     (misr_acc)
  );

  scan_bist_lfsr #(
    .NUM_CHAINS(NUM_CHAINS)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_load(seed_load),
    .advance  (load_phase),
    .state_q  (lfsr_state),
    .ps_out   (ps_bits)
  );

  scan_bist_misr #(
    .NUM_CHAINS(NUM_CHAINS)
  ) u_misr (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .accumulate(misr_acc),
    .data_in   (scan_out),
    .sig_q     (signature)
  );

  assign scan_in = load_phase ? ps_bits : '0;

endmodule

// File: rtl/scan_bist_chk.sv
module scan_bist_chk #(
  parameter int NUM_CHAINS = 25
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  scan_en,
  input logic                  capture_en,
  input logic                  done,
  input logic [NUM_CHAINS-1:0] scan_in,
  input logic [NUM_CHAINS-1:0] signature,
  input logic [31:0]           lfsr_state,
  input logic                  final_phase,
  input logic                  first_load
);

  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture_en)); // R10

  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> !capture_en); // R4

  AST_CAPTURE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_en) |-> $past(scan_en)); // R4

  AST_SOURCE_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> $stable(lfsr_state)); // R3

  AST_FINAL_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    final_phase |-> (scan_in == '0)); // R7

  AST_FIRST_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && first_load && !final_phase) |=> $stable(signature)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(signature))); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scan_en && !capture_en)); // R8

endmodule

bind scan_bist_seq scan_bist_chk #(
  .NUM_CHAINS(NUM_CHAINS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .scan_en    (scan_en),
  .capture_en (capture_en),
  .done       (done),
  .scan_in    (scan_in),
  .signature  (signature),
  .lfsr_state (lfsr_state),
  .final_phase(final_phase),
  .first_load (first_load)
);

// File: tb/scan_bist_seq_tb.sv
module scan_bist_seq_tb;

  localparam int N     = 25;
  localparam int L     = 200;
  localparam int CW    = 16;
  localparam int NVEC  = 4;
  localparam logic [31:0] SRC_SEED = 32'h1D87_2B41;
  localparam logic [N-1:0] SIG_SEED = '1;

  // Vector table: pattern count and expected edges from start to done
  localparam int VEC_P   [NVEC] = '{1, 2, 3, 0};
  localparam int VEC_LAT [NVEC] = '{402, 603, 804, 1};

  typedef logic [L-1:0] chain_t [N];

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] pattern_count = '0;
  logic          scan_en, capture_en, done;
  logic [N-1:0]  scan_in, scan_out, signature;

  chain_t chn;
  int checks = 0;
  int fails  = 0;
  int cap_cnt = 0;
  int both_hi = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  scan_bist_seq #(.NUM_CHAINS(N), .CHAIN_LEN(L), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern_count(pattern_count),
    .scan_en(scan_en), .capture_en(capture_en), .scan_in(scan_in),
    .scan_out(scan_out), .done(done), .signature(signature)
  );

  // Logic under test: nonlinear mix of neighbouring chain cells
  function automatic chain_t cut_fn(input chain_t c);
    chain_t r;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < L; j++)
        r[i][j] = c[i][j] ^ c[(i+1)%N][(j+3)%L] ^ (c[(i+2)%N][(j+7)%L] & c[i][(j+1)%L]);
    return r;
  endfunction

  function automatic logic [31:0] src_next(input logic [31:0] q);
    logic [31:0] mask = (32'h1 << 31) | (32'h1 << 21) | 32'h3;
    return (q << 1) | 32'(^(q & mask));
  endfunction

  function automatic logic [N-1:0] phase_word(input logic [31:0] q);
    logic [N-1:0] w;
    for (int i = 0; i < N; i++)
      w[i] = q[i % 32] ^ q[(3*i+5) % 32] ^ q[(7*i+11) % 32];
    return w;
  endfunction

  function automatic logic [N-1:0] sig_next(input logic [N-1:0] s, input logic [N-1:0] d);
    logic [N-1:0] r = (s << 1) | N'(s[N-1]);
    if (s[N-1]) r = r ^ N'(8);
    return r ^ d;
  endfunction

  function automatic logic [N-1:0] chain_tails(input chain_t c);
    logic [N-1:0] t;
    for (int i = 0; i < N; i++) t[i] = c[i][L-1];
    return t;
  endfunction

  // Chain models
  for (genvar gi = 0; gi < N; gi++) begin : g_tail
    assign scan_out[gi] = chn[gi][L-1];
  end

  always @(posedge clk) begin
    if (scan_en) begin
      for (int i = 0; i < N; i++) chn[i] <= {chn[i][L-2:0], scan_in[i]};
    end else if (capture_en) begin
      chn <= cut_fn(chn);
    end
    if (capture_en) cap_cnt <= cap_cnt + 1;
    if (scan_en && capture_en) both_hi <= both_hi + 1;
  end

  // Software golden signature for a run of p patterns
  function automatic logic [N-1:0] golden(input int p);
    chain_t g;
    logic [31:0] q = SRC_SEED;
    logic [N-1:0] s = SIG_SEED;
    logic [N-1:0] w;
    for (int i = 0; i < N; i++) g[i] = '0;
    if (p == 0) return s;
    for (int k = 0; k < p; k++) begin
      for (int t = 0; t < L; t++) begin
        if (k > 0) s = sig_next(s, chain_tails(g));
        w = phase_word(q);
        for (int i = 0; i < N; i++) g[i] = {g[i][L-2:0], w[i]};
        q = src_next(q);
      end
      g = cut_fn(g);
    end
    for (int t = 0; t < L; t++) begin
      s = sig_next(s, chain_tails(g));
      for (int i = 0; i < N; i++) g[i] = {g[i][L-2:0], 1'b0};
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Run p patterns; optionally pulse start mid-run; returns latency and first scan_in word
  task automatic run(input int p, input bit pulse, output int lat, output logic [N-1:0] first_in);
    cap_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    pattern_count = CW'(p);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    first_in = scan_in;
    while (!done && lat < 5000) begin
      start = (pulse && lat == 100);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [N-1:0] fin;
    logic [N-1:0] sig_a;
    bit zero;
    for (int i = 0; i < N; i++) chn[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!done && !scan_en && !capture_en, "R1 ctrl outs in reset", {done, scan_en, capture_en}, 0);
    check(scan_in == '0, "R1 scan_in in reset", scan_in, 0);
    check(signature == SIG_SEED, "R1 signature seed", signature, SIG_SEED);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !scan_en && signature == SIG_SEED, "R1 after release", signature, SIG_SEED);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      run(VEC_P[v], 1'b0, lat, fin);
      check(lat == VEC_LAT[v], "R8 latency", lat, VEC_LAT[v]);
      check(signature == golden(VEC_P[v]), "R5 R6 signature", signature, golden(VEC_P[v]));
      check(cap_cnt == VEC_P[v], "R4 capture count", cap_cnt, VEC_P[v]);
      if (VEC_P[v] > 0) begin
        check(fin == phase_word(SRC_SEED), "R3 first phase word", fin, phase_word(SRC_SEED));
        zero = 1'b1;
        for (int i = 0; i < N; i++) if (chn[i] != '0) zero = 1'b0;
        check(zero, "R7 chains zero after final pass", zero, 1);
      end else begin
        check(signature == SIG_SEED, "R8 zero patterns seed", signature, SIG_SEED);
      end
    end

    // R2: restart gives same signature; start mid-run ignored
    run(1, 1'b0, lat, fin);
    sig_a = signature;
    run(1, 1'b0, lat, fin);
    check(signature == sig_a, "R2 repeat run signature", signature, sig_a);
    run(2, 1'b1, lat, fin);
    check(lat == 603, "R2 start during run ignored latency", lat, 603);
    check(signature == golden(2), "R2 start during run ignored signature", signature, golden(2));

    // R9: hold in done
    sig_a = signature;
    repeat (20) @(negedge clk);
    check(done && signature == sig_a, "R9 done hold", signature, sig_a);
    check(!scan_en && !capture_en, "R8 quiet in done", {scan_en, capture_en}, 0);

    // R10: enables never overlap
    check(both_hi == 0, "R10 enable overlap", both_hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule